// File: doc/BRIEF.md
# HDLC Transmit Byte Queue with Host Status

This block sits between a host processor and an HDLC transmit framer. The host pushes payload bytes into a 128-entry queue, watching a full flag before each write. To close a message, the host first pulses an end-of-message control input and then writes the final byte. That byte is stored with a last-byte tag, and the control bit clears itself once the write is accepted. Each queue entry holds eight data bits and the tag.

The framer pulls bytes from the head of the queue with a request strobe. The head byte and its tag are visible whenever the queue is not empty. The block follows whether a message is open, meaning a byte has gone out but the tagged byte has not. It raises a one-cycle message-end event when the tagged byte leaves. It latches an underrun status if the framer asks for a byte while a message is open and the queue is empty. It also tells the framer when the line should carry idle flags.

The host sees four level indications: full, not full, empty and below half full.

Top module: `hdlc_txq_host`

## Requirements
- R1: After synchronous reset: level 0, empty=1, full=0, not_full=1, below_half=1, rd_valid=0, msg_done=0, underrun=0, idle_flags=1, eom_pending=0.
- R2: A write with wr_en=1 while full=0 is accepted, and level rises by one. Bytes leave in write order: rd_valid equals !empty, and rd_data shows the oldest byte. A cycle with rd_req=1 and rd_valid=1 removes that byte. A write and a removal in the same cycle leave the level unchanged.
- R3: A write while full=1 is dropped. The level stays 128, and the stored bytes and their order are unchanged.
- R4: full is 1 exactly when the level is 128, and not_full is always its inverse.
- R5: below_half is 1 exactly when the level is below 64.
- R6: A pulse on eom_set arms the end-of-message bit, shown on eom_pending. The next accepted write is stored with the tag, which appears on rd_eom=1 when that byte is at the head, and eom_pending returns to 0. eom_set in the same cycle as an accepted write tags that write. A dropped write leaves the bit armed.
- R7: msg_done is 1 for exactly the one cycle after a tagged byte is removed, and 0 otherwise.
- R8: underrun becomes 1 in the cycle after rd_req=1 is seen while a message is open and the queue is empty. A message is open after an untagged byte is removed and until a tagged byte is removed. underrun stays 1 until the first byte of the next message is removed.
- R9: idle_flags is 1 exactly when the queue is empty and no message is open.
- R10: rd_req on an empty queue with no message open removes nothing, produces no msg_done and leaves underrun unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| eom_set | input | 1 | Arms the end-of-message tag for the next accepted write |
| eom_pending | output | 1 | End-of-message tag armed and not yet used |
| full | output | 1 | Queue holds 128 bytes |
| not_full | output | 1 | Room for at least one byte |
| empty | output | 1 | Queue holds no bytes |
| below_half | output | 1 | Queue holds fewer than 64 bytes |
| level | output | 8 | Number of stored bytes |
| rd_req | input | 1 | Framer byte request |
| rd_valid | output | 1 | Head byte present |
| rd_data | output | 8 | Head byte |
| rd_eom | output | 1 | Head byte closes a message |
| msg_done | output | 1 | One-cycle event: tagged byte sent |
| underrun | output | 1 | Queue ran dry inside the current or last message |
| idle_flags | output | 1 | Framer should send idle flags |

## Verification
The hardest state to reach is an underrun. The queue must drain in the middle of a message while the framer keeps asking, and then a later message start must clear the status. Random traffic rarely lines this up. A directed sequence first fills the queue without any tag, with extra writes that must be dropped and an eom_set pulse that must survive them. It then drains the queue and keeps requesting to force the underrun. Finally it writes a tagged byte and a new message so the message end and the clearing are both observed. Long random phases then fill, drain and balance the queue with sparse tags, and a bench model tracks the order, the level, the open message and the status bits.

// File: rtl/hdlc_txq_pkg.sv
package hdlc_txq_pkg;

    localparam int TXQ_BYTE_W = 8;

    typedef struct packed {
        logic                  last;
        logic [TXQ_BYTE_W-1:0] data;
    } txq_entry_t;

    function automatic logic under_half(input int lvl, input int depth);
        return lvl < (depth / 2);
    endfunction

    function automatic int ptr_next(input int ptr, input int depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/hdlc_txq_store.sv
module hdlc_txq_store
    import hdlc_txq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_req,
    input  txq_entry_t      push_entry,
    input  logic            pop_req,
    output logic            push_ack,
    output logic            pop_ack,
    output txq_entry_t      head,
    output logic [CW-1:0]   count,
    output logic            is_full,
    output logic            is_empty
);

    txq_entry_t    slots [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;

    assign is_full  = (cnt == CW'(DEPTH));
    assign is_empty = (cnt == '0);
    assign push_ack = push_req && !is_full;
    assign pop_ack  = pop_req && !is_empty;
    assign head     = slots[rptr];
    assign count    = cnt;

    always_ff @(posedge clk) begin
        if (push_ack) begin
            slots[wptr] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ack) begin
                wptr <= AW'(ptr_next(int'(wptr), DEPTH));
            end
            if (pop_ack) begin
                rptr <= AW'(ptr_next(int'(rptr), DEPTH));
            end
            case ({push_ack, pop_ack})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/hdlc_txq_eom.sv
module hdlc_txq_eom (
    input  logic clk,
    input  logic rst,
    input  logic eom_set,
    input  logic push_ack,
    output logic tag,
    output logic armed
);

    logic arm_q;

    assign tag   = arm_q || eom_set;
    assign armed = arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
        end else if (push_ack) begin
            arm_q <= 1'b0;
        end else if (eom_set) begin
            arm_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_txq_track.sv
module hdlc_txq_track (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic pop_ack,
    input  logic head_last,
    input  logic is_empty,
    output logic done_evt,
    output logic dry_flag,
    output logic open_msg,
    output logic idle
);

    logic done_q, dry_q, open_q;

    assign done_evt = done_q;
    assign dry_flag = dry_q;
    assign open_msg = open_q;
    assign idle     = is_empty && !open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            dry_q  <= 1'b0;
            open_q <= 1'b0;
        end else begin
            done_q <= pop_ack && head_last;
            if (pop_ack) begin
                open_q <= !head_last;
                if (!open_q) begin
                    dry_q <= 1'b0;
                end
            end else if (req && is_empty && open_q) begin
                dry_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdlc_txq_host.sv
module hdlc_txq_host
    import hdlc_txq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [TXQ_BYTE_W-1:0] wr_data,
    input  logic                  eom_set,
    output logic                  eom_pending,
    output logic                  full,
    output logic                  not_full,
    output logic                  empty,
    output logic                  below_half,
    output logic [CW-1:0]         level,
    input  logic                  rd_req,
    output logic                  rd_valid,
    output logic [TXQ_BYTE_W-1:0] rd_data,
    output logic                  rd_eom,
    output logic                  msg_done,
    output logic                  underrun,
    output logic                  idle_flags
);

    txq_entry_t in_entry, head_entry;
    logic       push_ack, pop_ack, tag, open_msg;

    assign in_entry.last = tag;
    assign in_entry.data = wr_data;

    hdlc_txq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push_req   (wr_en),
        .push_entry (in_entry),
        .pop_req    (rd_req),
        .push_ack   (push_ack),
        .pop_ack    (pop_ack),
        .head       (head_entry),
        .count      (level),
        .is_full    (full),
        .is_empty   (empty)
    );

    hdlc_txq_eom u_eom (
        .clk      (clk),
        .rst      (rst),
        .eom_set  (eom_set),
        .push_ack (push_ack),
        .tag      (tag),
        .armed    (eom_pending)
    );

    hdlc_txq_track u_track (
        .clk       (clk),
        .rst       (rst),
        .req       (rd_req),
        .pop_ack   (pop_ack),
        .head_last (head_entry.last),
        .is_empty  (empty),
        .done_evt  (msg_done),
        .dry_flag  (underrun),
        .open_msg  (open_msg),
        .idle      (idle_flags)
    );

    assign not_full   = !full;
    assign below_half = under_half(int'(level), DEPTH);
    assign rd_valid   = !empty;
    assign rd_data    = head_entry.data;
    assign rd_eom     = head_entry.last;

endmodule

// File: rtl/hdlc_txq_host_chk.sv
module hdlc_txq_host_chk #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          eom_set,
    input logic          eom_pending,
    input logic          full,
    input logic          empty,
    input logic          below_half,
    input logic [CW-1:0] level,
    input logic          rd_req,
    input logic          rd_valid,
    input logic          rd_eom,
    input logic          msg_done,
    input logic          underrun,
    input logic          idle_flags
);

    p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
        (level == $past(level)) || (level == $past(level) + 1'b1) || (level + 1'b1 == $past(level)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        full && wr_en && !rd_req |=> full);

    p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    p_half_not_full_r5: assert property (@(posedge clk) disable iff (rst)
        below_half |-> !full);

    p_arm_clears_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en && !full |=> !eom_pending);

    p_arm_holds_r6: assert property (@(posedge clk) disable iff (rst)
        eom_set && !(wr_en && !full) |=> eom_pending);

    p_done_follows_r7: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_valid && rd_eom |=> msg_done);

    p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && rd_valid && rd_eom) |=> !msg_done);

    p_underrun_set_r8: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid && !idle_flags |=> underrun);

    p_idle_empty_r9: assert property (@(posedge clk) disable iff (rst)
        idle_flags |-> empty);

    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        rd_req && idle_flags && !underrun |=> !msg_done && !underrun);

endmodule

bind hdlc_txq_host hdlc_txq_host_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .eom_set     (eom_set),
    .eom_pending (eom_pending),
    .full        (full),
    .empty       (empty),
    .below_half  (below_half),
    .level       (level),
    .rd_req      (rd_req),
    .rd_valid    (rd_valid),
    .rd_eom      (rd_eom),
    .msg_done    (msg_done),
    .underrun    (underrun),
    .idle_flags  (idle_flags)
);

// File: tb/hdlc_txq_host_tb.sv
module hdlc_txq_host_tb;

    localparam int D = 128;

    logic       clk = 1'b0;
    logic       rst, wr_en, eom_set, rd_req;
    logic [7:0] wr_data;
    logic       eom_pending, full, not_full, empty, below_half;
    logic [7:0] level;
    logic       rd_valid, rd_eom, msg_done, underrun, idle_flags;
    logic [7:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    logic [8:0] mq [D];
    int m_head = 0, m_tail = 0, m_cnt = 0;
    bit m_arm = 0, m_open = 0, m_und = 0, m_done = 0;

    always #10 clk = ~clk;

    hdlc_txq_host #(.DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .eom_set(eom_set),
        .eom_pending(eom_pending), .full(full), .not_full(not_full), .empty(empty),
        .below_half(below_half), .level(level), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_eom(rd_eom), .msg_done(msg_done), .underrun(underrun),
        .idle_flags(idle_flags)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_half(input int c);
        return c < D / 2;
    endfunction

    task automatic compare_all();
        chk(int'(level) == m_cnt, "R2 level", int'(level), m_cnt);
        chk(empty == (m_cnt == 0), "R2 empty", int'(empty), int'(m_cnt == 0));
        chk(rd_valid == (m_cnt != 0), "R2 rd_valid", int'(rd_valid), int'(m_cnt != 0));
        if (m_cnt != 0) begin
            chk(rd_data == mq[m_head][7:0], "R2 rd_data", int'(rd_data), int'(mq[m_head][7:0]));
            chk(rd_eom == mq[m_head][8], "R6 rd_eom", int'(rd_eom), int'(mq[m_head][8]));
        end
        chk(full == (m_cnt == D), "R4 full", int'(full), int'(m_cnt == D));
        chk(not_full == (m_cnt != D), "R4 not_full", int'(not_full), int'(m_cnt != D));
        chk(below_half == exp_half(m_cnt), "R5 below_half", int'(below_half), int'(exp_half(m_cnt)));
        chk(eom_pending == m_arm, "R6 eom_pending", int'(eom_pending), int'(m_arm));
        chk(msg_done == m_done, "R7 msg_done", int'(msg_done), int'(m_done));
        chk(underrun == m_und, "R8 underrun", int'(underrun), int'(m_und));
        chk(idle_flags == (m_cnt == 0 && !m_open), "R9 idle_flags", int'(idle_flags),
            int'(m_cnt == 0 && !m_open));
    endtask

    // one cycle: compare at the falling edge, then drive and advance the model
    task automatic cyc(input bit w, input logic [7:0] d, input bit e, input bit r);
        bit acc, pop, tag;
        @(negedge clk);
        compare_all();
        wr_en = w; wr_data = d; eom_set = e; rd_req = r;
        acc = w && (m_cnt < D);
        pop = r && (m_cnt > 0);
        tag = m_arm || e;
        m_done = 0;
        if (pop) begin
            m_done = mq[m_head][8];
            if (!m_open) m_und = 0;
            m_open = !mq[m_head][8];
            m_head = (m_head + 1) % D;
            m_cnt--;
        end else if (r && m_cnt == 0 && m_open) begin
            m_und = 1;
        end
        if (acc) begin
            mq[m_tail] = {tag, d};
            m_tail = (m_tail + 1) % D;
            m_cnt++;
            m_arm = 0;
        end else if (e) begin
            m_arm = 1;
        end
    endtask

    initial begin
        for (int i = 0; i < 400000; i++) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pw, pr, pe, kind;
        logic [7:0] first_byte;
        void'($urandom(32'h5EED_1234));
        rst = 1; wr_en = 0; wr_data = 0; eom_set = 0; rd_req = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(level == 0 && empty && !full && not_full && below_half && !rd_valid, "R1 levels",
            int'(level), 0);
        chk(!msg_done && !underrun && idle_flags && !eom_pending, "R1 status",
            int'({msg_done, underrun, idle_flags, eom_pending}), 2);

        // R10: requests on an idle empty queue
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 1);
        cyc(0, 8'h00, 0, 0);
        chk(!underrun && !msg_done && level == 0, "R10 idle request", int'(underrun), 0);

        // fill without tag, overflow writes, arm during full
        for (int i = 0; i < D; i++) cyc(1, 8'(i * 3 + 1), 0, 0);
        first_byte = 8'd1;
        cyc(1, 8'hAA, 1, 0);
        cyc(1, 8'hBB, 0, 0);
        cyc(0, 8'h00, 0, 0);
        chk(level == 8'(D) && rd_data == first_byte && eom_pending, "R3 dropped writes",
            int'(rd_data), int'(first_byte));

        // drain fully, then keep asking: underrun inside open message
        for (int i = 0; i < D + 3; i++) cyc(0, 8'h00, 0, 1);
        cyc(0, 8'h00, 0, 0);
        chk(underrun == 1'b1, "R8 underrun raised", int'(underrun), 1);
        // armed tag applies to next write, closing the message
        cyc(1, 8'h5C, 0, 0);
        cyc(0, 8'h00, 0, 1);
        cyc(0, 8'h00, 0, 0);
        chk(underrun == 1'b1 && idle_flags, "R8 underrun held after end", int'(underrun), 1);
        // same-cycle eom with write: one-byte message clears underrun on pop
        cyc(1, 8'h77, 1, 0);
        cyc(0, 8'h00, 0, 1);
        cyc(0, 8'h00, 0, 0);
        chk(underrun == 1'b0, "R8 underrun cleared", int'(underrun), 0);

        // random phases
        for (int ph = 0; ph < 60; ph++) begin
            kind = ph % 3;
            pw = (kind == 0) ? 90 : (kind == 1) ? 15 : 55;
            pr = (kind == 0) ? 15 : (kind == 1) ? 90 : 50;
            pe = 12;
            for (int i = 0; i < 300; i++) begin
                cyc(($urandom % 100) < pw, 8'($urandom), ($urandom % 100) < pe,
                    ($urandom % 100) < pr);
            end
        end
        cyc(0, 8'h00, 0, 0);
        cyc(0, 8'h00, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule